// File: doc/BRIEF.md
# Prescaled Free-Running Timebase

This block is a 16-bit up-counter that runs freely and gives one shared time value to a group of capture and compare channels. Its count clock is the system clock divided by a power of two between 2 and 128. A 3-bit select input picks the divider. Plain control pins do four things: start and stop counting, clear the count, enable the overflow interrupt, and acknowledge an overflow.

When the count wraps from its all-ones value back to zero, a sticky overflow flag is set. The flag raises the interrupt output when the interrupt is enabled. A clear-on-match mode can also be turned on. In that mode, a match pulse from compare channel 0 makes the next count tick load zero instead of incrementing. This lets the compare channel set the period of the timebase.

All interfaces are level or pulse control and status pins. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure. The count output is registered and changes only on a count tick or a software clear.

Top module: `frt_timebase`

## Requirements
- R1: After reset, `count` is 0, `ovf_flag` is 0 and `ovf_irq` is 0.
- R2: For `div_sel` values 0 to 6, `count` increments once every 2^(`div_sel`+1) clock cycles while `run` is high (code 0 gives /2, code 6 gives /128).
- R3: The unused code `div_sel` = 7 gives divide-by-2.
- R4: While `run` is low, `count` holds its value and the prescaler phase is held at zero. After `run` rises again, the first increment comes only after a full divider period.
- R5: A one-cycle `sw_clear` pulse sets `count` to 0 and resets the prescaler phase on the same clock edge. It takes priority over counting and over clear-on-match.
- R6: When an increment takes `count` from 0xFFFF to 0x0000, `ovf_flag` is set on that same edge.
- R7: `ovf_irq` is high exactly when `ovf_flag` and `ovf_irq_en` are both high.
- R8: `ovf_flag` stays set until a cycle with `ovf_ack` high clears it. If a wrap happens in the same cycle as the acknowledge, the flag stays set.
- R9: When `clr_on_match` is high, a `cmp0_match` pulse is remembered. On the next count tick, `count` becomes 0 instead of incrementing. Only that one tick is affected, and the load does not set `ovf_flag`.
- R10: When `clr_on_match` is low, `cmp0_match` has no effect on `count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_sel | input | 3 | Count clock divider select: /2^(code+1); code 7 gives /2 |
| run | input | 1 | Count enable |
| sw_clear | input | 1 | Software clear of count and prescaler phase |
| clr_on_match | input | 1 | Enables clearing by compare channel 0 |
| cmp0_match | input | 1 | Match pulse from compare channel 0 |
| ovf_irq_en | input | 1 | Overflow interrupt enable |
| ovf_ack | input | 1 | Write-one-to-clear for the overflow flag |
| count | output | 16 | Live timebase value |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
Assertions check the following on every cycle:
- `count` holds while stopped.
- A software clear zeroes `count` on the next edge.
- A plain tick increments `count` by one.
- A match tick in clear-on-match mode zeroes `count`.
- A wrap sets the flag, and the flag stays set without an acknowledge, including when a wrap and an acknowledge fall in the same cycle.

Only the bench scenarios can show the following:
- The exact divider period for each select code, including the reserved code.
- The phase restart after a stop or a clear.
- The one full 16-bit wrap.
- That a match pulse is ignored when clear-on-match mode is off.

// File: rtl/frt_pkg.sv
package frt_pkg;
  localparam int unsigned FRT_CNT_W = 16;
  localparam int unsigned FRT_SEL_W = 3;
  localparam int unsigned FRT_PS_W  = (1 << FRT_SEL_W) - 1;

  typedef enum logic [FRT_SEL_W-1:0] {
    DIV_2   = 3'd0,
    DIV_4   = 3'd1,
    DIV_8   = 3'd2,
    DIV_16  = 3'd3,
    DIV_32  = 3'd4,
    DIV_64  = 3'd5,
    DIV_128 = 3'd6,
    DIV_RSV = 3'd7
  } div_code_e;
endpackage

// File: rtl/frt_prescaler.sv
module frt_prescaler #(
  parameter int unsigned SEL_W = frt_pkg::FRT_SEL_W,
  parameter int unsigned PS_W  = frt_pkg::FRT_PS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PS_W-1:0] phase;
  logic [PS_W-1:0] limit;

  // terminal phase value for each select code; out-of-range codes fall back to /2
  always_comb begin
    if (int'(sel) < int'(PS_W))
      limit = PS_W'((1 << (int'(sel) + 1)) - 1);
    else
      limit = PS_W'(1);
  end

  assign tick = run && !restart && (phase >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)
      phase <= '0;
    else if (!run || restart || tick)
      phase <= '0;
    else
      phase <= phase + 1'b1;
  end
endmodule

// File: rtl/frt_counter.sv
module frt_counter #(
  parameter int unsigned CNT_W = frt_pkg::FRT_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic             clr_mode,
  input  logic             match,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  logic pend;
  logic load_zero;

  assign load_zero = clr_mode && (pend || match);
  assign wrap      = tick && !restart && !load_zero && (&count);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      pend  <= 1'b0;
    end else if (restart) begin
      count <= '0;
      pend  <= 1'b0;
    end else if (tick) begin
      pend  <= 1'b0;
      count <= load_zero ? '0 : count + 1'b1;
    end else if (clr_mode && match) begin
      pend <= 1'b1;
    end
  end

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> count == '0);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(count));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart && !clr_mode) |=> count == $past(count) + 1'b1);

  assert_match_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart && clr_mode && match) |=> count == '0);
endmodule

// File: rtl/frt_ovf.sv
module frt_ovf (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic ack,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      flag <= 1'b0;
    else if (set_evt)
      flag <= 1'b1;
    else if (ack)
      flag <= 1'b0;
  end

  assign irq = flag & irq_en;

  assert_ovf_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag);

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !ack) |=> flag);

  assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !flag |-> !irq);
endmodule

// File: rtl/frt_timebase.sv
module frt_timebase #(
  parameter int unsigned CNT_W = frt_pkg::FRT_CNT_W,
  parameter int unsigned SEL_W = frt_pkg::FRT_SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             run,
  input  logic             sw_clear,
  input  logic             clr_on_match,
  input  logic             cmp0_match,
  input  logic             ovf_irq_en,
  input  logic             ovf_ack,
  output logic [CNT_W-1:0] count,
  output logic             ovf_flag,
  output logic             ovf_irq
);
  localparam int unsigned PS_W = (1 << SEL_W) - 1;

  logic tick;
  logic wrap;

  frt_prescaler #(.SEL_W(SEL_W), .PS_W(PS_W)) u_ps (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(sw_clear),
    .sel(div_sel), .tick(tick)
  );

  frt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .restart(sw_clear),
    .clr_mode(clr_on_match), .match(cmp0_match), .count(count), .wrap(wrap)
  );

  frt_ovf u_ovf (
    .clk(clk), .rst_n(rst_n), .set_evt(wrap), .ack(ovf_ack),
    .irq_en(ovf_irq_en), .flag(ovf_flag), .irq(ovf_irq)
  );

  assert_stop_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !sw_clear) |=> $stable(count));

  assert_ovf_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && ovf_ack) |=> ovf_flag);
endmodule

// File: tb/frt_timebase_tb_top.sv
module frt_timebase_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  div_sel = 3'd0;
  logic        run = 1'b0, sw_clear = 1'b0, clr_on_match = 1'b0;
  logic        cmp0_match = 1'b0, ovf_irq_en = 1'b0, ovf_ack = 1'b0;
  logic [15:0] count;
  logic        ovf_flag, ovf_irq;
  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  frt_timebase dut_i (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .run(run), .sw_clear(sw_clear),
    .clr_on_match(clr_on_match), .cmp0_match(cmp0_match), .ovf_irq_en(ovf_irq_en),
    .ovf_ack(ovf_ack), .count(count), .ovf_flag(ovf_flag), .ovf_irq(ovf_irq)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // clear and start counting with given select; returns right after the clear edge
  task automatic restart_run(input logic [2:0] sel);
    div_sel = sel; run = 1'b1; sw_clear = 1'b1;
    step(1);
    sw_clear = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 count", 32'(count), 0);
    chk("R1 flag", 32'(ovf_flag), 0);
    chk("R1 irq", 32'(ovf_irq), 0);
  endtask

  task automatic t_dividers();
    for (int s = 0; s < 8; s++) begin
      int per;
      per = (s == 7) ? 2 : (1 << (s + 1));
      restart_run(3'(s));
      step(5 * per - 1);
      chk(s == 7 ? "R3 before tick" : "R2 before tick", 32'(count), 4);
      step(1);
      chk(s == 7 ? "R3 on tick" : "R2 on tick", 32'(count), 5);
    end
  endtask

  task automatic t_stop();
    restart_run(3'd0);
    step(21);
    chk("R4 running", 32'(count), 10);
    run = 1'b0;
    step(30);
    chk("R4 hold", 32'(count), 10);
    run = 1'b1;
    step(1);
    chk("R4 phase restart", 32'(count), 10);
    step(1);
    chk("R4 first tick", 32'(count), 11);
  endtask

  task automatic t_swclear();
    restart_run(3'd1);
    step(10);
    chk("R5 pre", 32'(count), 2);
    sw_clear = 1'b1;
    step(1);
    sw_clear = 1'b0;
    chk("R5 cleared", 32'(count), 0);
    step(3);
    chk("R5 phase reset", 32'(count), 0);
    step(1);
    chk("R5 first tick", 32'(count), 1);
  endtask

  task automatic t_match();
    clr_on_match = 1'b1;
    restart_run(3'd2);
    step(26);
    cmp0_match = 1'b1; step(1); cmp0_match = 1'b0;
    step(4);
    chk("R9 before tick", 32'(count), 3);
    step(1);
    chk("R9 zero on tick", 32'(count), 0);
    chk("R9 no ovf", 32'(ovf_flag), 0);
    step(8);
    chk("R9 one-shot", 32'(count), 1);
    clr_on_match = 1'b0;
    restart_run(3'd2);
    step(26);
    cmp0_match = 1'b1; step(1); cmp0_match = 1'b0;
    step(5);
    chk("R10 ignored", 32'(count), 4);
  endtask

  task automatic t_overflow();
    ovf_irq_en = 1'b0;
    restart_run(3'd0);
    step(131070);
    chk("R6 at max", 32'(count), 32'hFFFF);
    chk("R6 flag low", 32'(ovf_flag), 0);
    ovf_ack = 1'b1;
    step(2);
    ovf_ack = 1'b0;
    chk("R6 wrapped", 32'(count), 0);
    chk("R8 set wins over ack", 32'(ovf_flag), 1);
    chk("R7 irq masked", 32'(ovf_irq), 0);
    ovf_irq_en = 1'b1;
    step(1);
    chk("R7 irq on", 32'(ovf_irq), 1);
    step(10);
    chk("R8 sticky", 32'(ovf_flag), 1);
    ovf_ack = 1'b1; step(1); ovf_ack = 1'b0;
    chk("R8 acked", 32'(ovf_flag), 0);
    chk("R7 irq off", 32'(ovf_irq), 0);
  endtask

  initial begin
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(1);
    t_dividers();
    t_stop();
    t_swclear();
    t_match();
    t_overflow();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule